// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial clock of an SPI controller from the controller's functional clock. A small divide code picks one of eight even ratios between 2 and 16. A separate bypass input runs the serial clock at the full functional rate and overrides the code. A polarity input sets the level the serial clock rests at between transfers. The block runs the serial clock only while a transfer is requested, and always finishes the current word before it stops.

Alongside the clock it gives a shift register built for clock phase 0 two single-cycle strobes. One marks the cycle that ends with each leading edge, which is when the shifter samples. The other marks the cycle that ends with each trailing edge, which is when the shifter launches the next bit. A word-end pulse marks the last trailing edge of each 8-bit word. The divide code, bypass and polarity are captured when a transfer starts and again at each word boundary, so a change made mid-word never distorts a word already in flight.

Top module: `spi_sclk_gen`

## Requirements
- R1: With bypass low, the serial clock period is 2×(div_code+1) functional-clock cycles, so codes 0 to 7 give ratios 2, 4, 6, 8, 10, 12, 14 and 16.
- R2: In divided mode the idle-level phase and the active-level phase each last div_code+1 cycles. The first phase after a start is the idle-level phase.
- R3: sample_stb is high only in the cycle that ends with a leading edge, and shift_stb only in the cycle that ends with a trailing edge. In divided mode each fires once per serial clock period and the two are never high together.
- R4: With bypass high, div_code has no effect. The serial clock is at its active level while clk is high and at its idle level while clk is low, and both strobes are high in every running cycle.
- R5: While idle, sclk equals clk_pol. While running, the idle level is the clk_pol value captured at the last start or word boundary, and the active level is its inverse.
- R6: While idle no strobe is produced. A transfer starts in the cycle after xfer_active is seen high while idle.
- R7: Changes on div_code, div_bypass and clk_pol take effect only at the next start or word boundary, where a word boundary is the 8th trailing edge.
- R8: byte_end is high together with the 8th shift_stb of each word. If xfer_active is low in that cycle the block is idle in the next cycle; otherwise the next word follows with no gap.
- R9: While reset is held the block is idle: sclk equals clk_pol and sample_stb, shift_stb and byte_end are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | Transfer request; sampled at start and at each word end |
| div_code | input | 3 | Divide code; ratio 2×(code+1) |
| div_bypass | input | 1 | Run the serial clock at the functional rate |
| clk_pol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | Cycle ending in a leading edge |
| shift_stb | output | 1 | Cycle ending in a trailing edge |
| byte_end | output | 1 | Last trailing edge of an 8-bit word |

## Verification
The hardest case to reach is a configuration change that lands inside a word, because the ports give no sign of which cycle falls mid-word. The bench starts a word at a small ratio and rewrites the divide code and polarity a few cycles later. It also keeps xfer_active high across several words while switching between bypass and divided mode, so every new setting falls due at a word boundary. A cycle-level model in the bench tracks each word boundary and flags any change in the period or the level before it.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

   // level of the serial clock relative to the captured polarity
   typedef enum logic {
      PH_REST = 1'b0,
      PH_DRIVE = 1'b1
   } sclk_phase_e;

   // configuration captured at start and word boundaries
   typedef struct packed {
      logic byp;
      logic pol;
   } sclk_mode_t;

   function automatic int unsigned ratio_of(input int unsigned code);
      return 2 * (code + 1);
   endfunction

endpackage

// File: rtl/spi_sclk_cfg.sv
module spi_sclk_cfg
   import spi_sclk_pkg::*;
#(
   parameter int unsigned CODE_W = 3,
   parameter bit ALLOW_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              byp_i,
   input  logic              pol_i,
   output logic [CODE_W-1:0] code_o,
   output sclk_mode_t        mode_o
);

   logic byp_eff;

   generate
      if (ALLOW_BYPASS) begin : g_byp
         assign byp_eff = byp_i;
      end else begin : g_nobyp
         assign byp_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         mode_o <= '0;
      end else if (load_i) begin
         code_o     <= code_i;
         mode_o.byp <= byp_eff;
         mode_o.pol <= pol_i;
      end
   end

endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer
   import spi_sclk_pkg::*;
#(
   parameter int unsigned CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] load_code_i,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] hold_code_i,
   output sclk_phase_e       phase_o,
   output logic              cnt_zero_o
);

   logic [CODE_W-1:0] cnt;

   assign cnt_zero_o = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         phase_o <= PH_REST;
      end else if (load_i) begin
         cnt     <= load_code_i;
         phase_o <= PH_REST;
      end else if (tick_i) begin
         if (cnt_zero_o) begin
            cnt     <= hold_code_i;
            phase_o <= (phase_o == PH_REST) ? PH_DRIVE : PH_REST;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_sclk_bitcnt.sv
module spi_sclk_bitcnt #(
   parameter int unsigned BITS_PER_WORD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic last_o
);

   localparam int unsigned BIT_W = (BITS_PER_WORD > 1) ? $clog2(BITS_PER_WORD) : 1;
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(BITS_PER_WORD - 1);

   logic [BIT_W-1:0] idx;

   assign last_o = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clear_i) begin
         idx <= '0;
      end else if (step_i) begin
         idx <= last_o ? '0 : idx + 1'b1;
      end
   end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
   import spi_sclk_pkg::*;
#(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned BITS_PER_WORD = 8,
   parameter bit ALLOW_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_active,
   input  logic [CODE_W-1:0] div_code,
   input  logic              div_bypass,
   input  logic              clk_pol,
   output logic              sclk,
   output logic              sample_stb,
   output logic              shift_stb,
   output logic              byte_end
);

   localparam int unsigned MAX_RATIO = ratio_of((1 << CODE_W) - 1);

   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
         $error("spi_sclk_gen: CODE_W must be 1..8");
      end
      if (BITS_PER_WORD < 2) begin : g_bad_word
         $error("spi_sclk_gen: BITS_PER_WORD must be at least 2");
      end
      if (MAX_RATIO < 2) begin : g_bad_ratio
         $error("spi_sclk_gen: derived ratio out of range");
      end
   endgenerate

   logic              run;
   logic              start;
   logic              lead;
   logic              trail;
   logic              word_last;
   logic              word_end;
   logic              load;
   logic [CODE_W-1:0] code_r;
   sclk_mode_t        mode_r;
   sclk_phase_e       phase;
   logic              cnt_zero;

   assign start    = xfer_active & ~run;
   assign lead     = run & (mode_r.byp | ((phase == PH_REST) & cnt_zero));
   assign trail    = run & (mode_r.byp | ((phase == PH_DRIVE) & cnt_zero));
   assign word_end = trail & word_last;
   assign load     = start | (word_end & xfer_active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
      end else if (start) begin
         run <= 1'b1;
      end else if (word_end & ~xfer_active) begin
         run <= 1'b0;
      end
   end

   spi_sclk_cfg #(
      .CODE_W      (CODE_W),
      .ALLOW_BYPASS(ALLOW_BYPASS)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .code_i(div_code),
      .byp_i (div_bypass),
      .pol_i (clk_pol),
      .code_o(code_r),
      .mode_o(mode_r)
   );

   spi_sclk_timer #(
      .CODE_W(CODE_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_code_i(div_code),
      .tick_i     (run & ~mode_r.byp),
      .hold_code_i(code_r),
      .phase_o    (phase),
      .cnt_zero_o (cnt_zero)
   );

   spi_sclk_bitcnt #(
      .BITS_PER_WORD(BITS_PER_WORD)
   ) u_bits (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(start),
      .step_i (trail),
      .last_o (word_last)
   );

   generate
      if (ALLOW_BYPASS) begin : g_out_byp
         assign sclk = run ? (mode_r.pol ^ (mode_r.byp ? clk : phase == PH_DRIVE)) : clk_pol;
      end else begin : g_out_div
         assign sclk = run ? (mode_r.pol ^ (phase == PH_DRIVE)) : clk_pol;
      end
   endgenerate

   assign sample_stb = lead;
   assign shift_stb  = trail;
   assign byte_end   = word_end;

endmodule

// File: rtl/spi_sclk_chk.sv
module spi_sclk_chk #(
   parameter int unsigned CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              byp,
   input logic              pol,
   input logic [CODE_W-1:0] code,
   input logic              sclk,
   input logic              sample_stb,
   input logic              shift_stb,
   input logic              byte_end
);

   assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb || shift_stb) |-> run);

   assert_end_on_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_end |-> shift_stb);

   assert_stop_at_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> $past(byte_end));

   assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !byp) |-> !(sample_stb && shift_stb));

   assert_level_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !byp && !$past(byp) && !$past(sample_stb) && !$past(shift_stb))
      |-> $stable(sclk));

   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(byte_end)) |-> ($stable(code) && $stable(byp) && $stable(pol)));

endmodule

bind spi_sclk_gen spi_sclk_chk #(
   .CODE_W(CODE_W)
) u_sclk_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .byp       (mode_r.byp),
   .pol       (mode_r.pol),
   .code      (code_r),
   .sclk      (sclk),
   .sample_stb(sample_stb),
   .shift_stb (shift_stb),
   .byte_end  (byte_end)
);

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 60000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xa = 1'b0;
   logic [2:0] code = 3'd0;
   logic       byp = 1'b0;
   logic       pol = 1'b0;
   logic       sclk, sample_stb, shift_stb, byte_end;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   string cur_req = "R9";

   // reference model state
   bit m_run = 0;
   bit m_byp = 0;
   bit m_pol = 0;
   int m_half = 1;
   int m_pos = 0;
   int m_bit = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_sclk_gen i_spi_sclk_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_active(xa),
      .div_code   (code),
      .div_bypass (byp),
      .clk_pol    (pol),
      .sclk       (sclk),
      .sample_stb (sample_stb),
      .shift_stb  (shift_stb),
      .byte_end   (byte_end)
   );

   function automatic bit exp_shift();
      return m_run && (m_byp || m_pos == 2*m_half - 1);
   endfunction

   function automatic bit exp_sample();
      return m_run && (m_byp || m_pos == m_half - 1);
   endfunction

   function automatic bit exp_sclk();
      if (!m_run) return pol;
      if (m_byp) return ~m_pol;   // sampled while clk is high
      return m_pol ^ (m_pos >= m_half);
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: {sclk,sample,shift,end} actual=%b expected=%b",
                  req, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         if (!m_run) begin
            if (xa) begin
               m_run = 1; m_byp = byp; m_pol = pol;
               m_half = int'(code) + 1; m_pos = 0; m_bit = 0;
            end
         end else if (exp_shift()) begin
            if (m_bit == 7) begin
               m_bit = 0; m_pos = 0;
               if (xa) begin
                  m_byp = byp; m_pol = pol; m_half = int'(code) + 1;
               end else begin
                  m_run = 0;
               end
            end else begin
               m_bit++; m_pos = 0;
            end
         end else begin
            m_pos++;
         end
      end
      #2;
      if (rst_n && !done)
         check(cur_req, {sclk, sample_stb, shift_stb, byte_end},
               {exp_sclk(), exp_sample(), exp_shift(), exp_shift() && m_bit == 7});
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic one_word(input logic [2:0] c, input logic b, input logic p);
      @(negedge clk);
      code = c; byp = b; pol = p; xa = 1'b1;
      @(negedge clk);
      xa = 1'b0;
      cycles(16 * (int'(c) + 1) + 4);
   endtask

   initial begin
      // R9: reset state with both polarities
      pol = 1'b1;
      cycles(2);
      check("R9", {sclk, sample_stb, shift_stb, byte_end}, 4'b1000);
      pol = 1'b0;
      #1;
      check("R9", {sclk, sample_stb, shift_stb, byte_end}, 4'b0000);
      cycles(1);
      rst_n = 1'b1;
      cycles(3);

      // R6: idle with inputs moving, no transfer request
      cur_req = "R6";
      code = 3'd5; byp = 1'b1; pol = 1'b1;
      cycles(4);
      pol = 1'b0;
      cycles(4);

      // R1 and R2: every divide code, one word each
      cur_req = "R1";
      for (int c = 0; c < 8; c++) one_word(3'(c), 1'b0, 1'b0);
      cur_req = "R2";
      one_word(3'd3, 1'b0, 1'b0);

      // R3: strobes around edges at ratio 6
      cur_req = "R3";
      one_word(3'd2, 1'b0, 1'b0);

      // R5: inverted polarity
      cur_req = "R5";
      one_word(3'd2, 1'b0, 1'b1);
      cycles(3);

      // R4: bypass with a non-zero code
      cur_req = "R4";
      @(negedge clk);
      code = 3'd5; byp = 1'b1; pol = 1'b0; xa = 1'b1;
      cycles(12);
      xa = 1'b0;
      cycles(10);

      // R7: mid-word changes of code and polarity
      cur_req = "R7";
      @(negedge clk);
      code = 3'd1; byp = 1'b0; pol = 1'b0; xa = 1'b1;
      cycles(5);
      code = 3'd4; pol = 1'b1;
      cycles(20);
      code = 3'd0; byp = 1'b1;
      cycles(50);
      byp = 1'b0; code = 3'd2;
      cycles(10);
      xa = 1'b0;
      cycles(60);

      // R8: back-to-back words, request dropped mid third word
      cur_req = "R8";
      @(negedge clk);
      code = 3'd0; byp = 1'b0; pol = 1'b0; xa = 1'b1;
      cycles(40);
      xa = 1'b0;
      cycles(6);
      xa = 1'b1;
      cycles(1);
      xa = 1'b0;
      cycles(40);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule